// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary token latches shared between a left and a right port. Each port has its own active-low select for the semaphore space, a write strobe, a latch index, a one-bit write datum and a one-bit read-back. Software on either side takes a token by writing 0 to a latch. It then reads the latch back: 0 means the token is its own, and 1 means the other side holds it. Writing 1 gives the token up.

The bank enforces single ownership. A request that finds the token held by the other side stays queued. The token passes to the waiting side on the clock edge that follows the owner's release. When both sides ask for the same free token in one cycle, the left side wins and the right request waits. A side that no longer wants a token it is waiting for writes 1 to drop the queued request. No operation ever stalls a port, and the read-back of the indexed latch appears in the same cycle the index is presented. The latches gate no hardware resource: their meaning is set by software.

Top module: `sem_bank`

## Requirements
- R1: After reset, every latch is free, and both ports read 1 from every index.
- R2: While a port's select is high, its writes have no effect and its read-back output is 1.
- R3: A write of data bit 0 to a free latch gives that port ownership from the next clock edge. The owner then reads 0 at that index, and the other port reads 1.
- R4: While one port owns a latch, a write of 0 from the other port does not give the other port ownership.
- R5: A write of 1 by the owner releases the latch when no request is queued, and both ports then read 1.
- R6: A request made while the other port owns the latch stays queued. The token passes to the queued port on the edge that ends the owner's releasing write, so that port reads 0 in the next cycle.
- R7: When both ports write 0 to the same free latch in one cycle, the left port gets ownership and the right request stays queued.
- R8: A write of 1 by a port that does not own the latch cancels that port's queued request and leaves the owner unchanged. A later release by the owner then leaves the latch free.
- R9: The latches are independent. An operation on one index changes no other latch, and the two ports may own different latches at the same time.
- R10: The read-back is combinational in the index and select and needs no clock edge. The write strobe is 1 for a write and 0 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_idx | input | 3 | Left latch index |
| l_din | input | 1 | Left write datum (0 request, 1 release) |
| l_dout | output | 1 | Left read-back (0 means left owns the indexed latch) |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_idx | input | 3 | Right latch index |
| r_din | input | 1 | Right write datum (0 request, 1 release) |
| r_dout | output | 1 | Right read-back (0 means right owns the indexed latch) |

## Verification
The bench targets the cycle in which the owner releases while a request is queued. A design that frees the latch instead of handing it over leaves the waiting port reading 1. The bench also drives simultaneous requests for a free latch. A design with the wrong priority grants the right side, and one that drops the losing request never hands it the token. Finally, it cancels a queued request with a write of 1 from the non-owner. A design that ignores the cancel later passes the token to a port that no longer wants it, and one that treats the cancel as a release frees the owner's token.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   pend_l;
        logic   pend_r;
    } cell_t;

    localparam cell_t CELL_RESET = '{owner: OWN_NONE, pend_l: 1'b0, pend_r: 1'b0};
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic               sel_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic               din,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel
);
    logic wr_ok;
    assign wr_ok = ~sel_n & we;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        assign req[g] = wr_ok & (idx == IDX_W'(g)) & ~din;
        assign rel[g] = wr_ok & (idx == IDX_W'(g)) &  din;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r
);
    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.owner)
            OWN_NONE: begin
                if (req_l) begin
                    st_d.owner  = OWN_LEFT;
                    st_d.pend_r = req_r;
                end else if (req_r) begin
                    st_d.owner  = OWN_RIGHT;
                end
                if (rel_l) st_d.pend_l = 1'b0;
                if (rel_r) st_d.pend_r = 1'b0;
            end
            OWN_LEFT: begin
                if (rel_l) begin
                    if ((st_q.pend_r || req_r) && !rel_r) begin
                        st_d.owner = OWN_RIGHT;
                    end else begin
                        st_d.owner = OWN_NONE;
                    end
                    st_d.pend_r = 1'b0;
                end else begin
                    if (req_r) st_d.pend_r = 1'b1;
                    if (rel_r) st_d.pend_r = 1'b0;
                end
                st_d.pend_l = 1'b0;
            end
            OWN_RIGHT: begin
                if (rel_r) begin
                    if ((st_q.pend_l || req_l) && !rel_l) begin
                        st_d.owner = OWN_LEFT;
                    end else begin
                        st_d.owner = OWN_NONE;
                    end
                    st_d.pend_l = 1'b0;
                end else begin
                    if (req_l) st_d.pend_l = 1'b1;
                    if (rel_l) st_d.pend_l = 1'b0;
                end
                st_d.pend_r = 1'b0;
            end
            default: st_d = CELL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CELL_RESET;
        else        st_q <= st_d;
    end

    assign own_l = (st_q.owner == OWN_LEFT);
    assign own_r = (st_q.owner == OWN_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel_n,
    input  logic             l_we,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_din,
    output logic             l_dout,
    input  logic             r_sel_n,
    input  logic             r_we,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_din,
    output logic             r_dout
);
    logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
    logic [NUM_SEM-1:0] own_l, own_r;

    sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_l (
        .sel_n(l_sel_n), .we(l_we), .idx(l_idx), .din(l_din),
        .req(req_l), .rel(rel_l)
    );

    sem_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_r (
        .sel_n(r_sel_n), .we(r_we), .idx(r_idx), .din(r_din),
        .req(req_r), .rel(rel_r)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l[g]), .rel_l(rel_l[g]),
            .req_r(req_r[g]), .rel_r(rel_r[g]),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    assign l_dout = l_sel_n | ~own_l[l_idx];
    assign r_dout = r_sel_n | ~own_r[r_idx];
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    localparam int IDX_W = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel_n,
    input logic               l_we,
    input logic [IDX_W-1:0]   l_idx,
    input logic               l_din,
    input logic               r_sel_n,
    input logic               r_we,
    input logic               r_din,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r
);
    // R3
    left_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && l_we && !l_din && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

    // R4
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_r[l_idx] && !(!r_sel_n && r_we && r_din)) |=> !own_l[$past(l_idx)]);

    // R5
    left_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && l_we && l_din && own_l[l_idx]) |=> !own_l[$past(l_idx)]);

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel_n && r_sel_n) |=> ($stable(own_l) && $stable(own_r)));
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_we(l_we), .l_idx(l_idx), .l_din(l_din),
    .r_sel_n(r_sel_n), .r_we(r_we), .r_din(r_din),
    .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel_n = 1'b1, l_we = 1'b0, l_din = 1'b1;
    logic [2:0] l_idx = 3'd0;
    logic       r_sel_n = 1'b1, r_we = 1'b0, r_din = 1'b1;
    logic [2:0] r_idx = 3'd0;
    logic       l_dout, r_dout;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sem_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_we(l_we), .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout),
        .r_sel_n(r_sel_n), .r_we(r_we), .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one write cycle on either or both ports; sel=1 means the port writes
    task automatic wr(input logic ls, input logic [2:0] li, input logic ld,
                      input logic rs, input logic [2:0] ri, input logic rd);
        @(negedge clk);
        l_sel_n = ~ls; l_we = ls; l_idx = li; l_din = ld;
        r_sel_n = ~rs; r_we = rs; r_idx = ri; r_din = rd;
        @(posedge clk);
        @(negedge clk);
        l_sel_n = 1'b1; l_we = 1'b0; r_sel_n = 1'b1; r_we = 1'b0;
    endtask

    // read both ports without a clock edge
    task automatic peek(input logic [2:0] li, input logic [2:0] ri,
                        input logic el, input logic er, input string req);
        l_sel_n = 1'b0; l_we = 1'b0; l_idx = li;
        r_sel_n = 1'b0; r_we = 1'b0; r_idx = ri;
        #2;
        check({req, " left"}, l_dout, el);
        check({req, " right"}, r_dout, er);
        l_sel_n = 1'b1; r_sel_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) peek(3'(i), 3'(i), 1'b1, 1'b1, "R1");
    endtask

    task automatic t_grant_block_handoff();
        wr(1, 3'd2, 0, 0, 3'd0, 1);
        peek(3'd2, 3'd2, 1'b0, 1'b1, "R3");
        wr(0, 3'd0, 1, 1, 3'd2, 0);
        peek(3'd2, 3'd2, 1'b0, 1'b1, "R4");
        wr(1, 3'd2, 1, 0, 3'd0, 1);
        peek(3'd2, 3'd2, 1'b1, 1'b0, "R6");
        wr(0, 3'd0, 1, 1, 3'd2, 1);
        peek(3'd2, 3'd2, 1'b1, 1'b1, "R5");
    endtask

    task automatic t_tie();
        wr(1, 3'd5, 0, 1, 3'd5, 0);
        peek(3'd5, 3'd5, 1'b0, 1'b1, "R7");
        wr(1, 3'd5, 1, 0, 3'd0, 1);
        peek(3'd5, 3'd5, 1'b1, 1'b0, "R7 queued");
        wr(0, 3'd0, 1, 1, 3'd5, 1);
        peek(3'd5, 3'd5, 1'b1, 1'b1, "R7 cleanup");
    endtask

    task automatic t_cancel();
        wr(1, 3'd3, 0, 0, 3'd0, 1);
        wr(0, 3'd0, 1, 1, 3'd3, 0);
        wr(0, 3'd0, 1, 1, 3'd3, 1);
        peek(3'd3, 3'd3, 1'b0, 1'b1, "R8 owner kept");
        wr(1, 3'd3, 1, 0, 3'd0, 1);
        peek(3'd3, 3'd3, 1'b1, 1'b1, "R8 freed");
    endtask

    task automatic t_deselect();
        @(negedge clk);
        l_sel_n = 1'b1; l_we = 1'b1; l_idx = 3'd4; l_din = 1'b0;
        @(posedge clk);
        @(negedge clk);
        l_we = 1'b0;
        peek(3'd4, 3'd4, 1'b1, 1'b1, "R2 write ignored");
        wr(1, 3'd1, 0, 0, 3'd0, 1);
        l_sel_n = 1'b1; l_idx = 3'd1;
        #2;
        check("R2 deselected output", l_dout, 1'b1);
        wr(1, 3'd1, 1, 0, 3'd0, 1);
    endtask

    task automatic t_indep();
        wr(1, 3'd6, 0, 1, 3'd7, 0);
        peek(3'd6, 3'd7, 1'b0, 1'b0, "R9 both own");
        peek(3'd0, 3'd0, 1'b1, 1'b1, "R9 other free");
        peek(3'd7, 3'd6, 1'b1, 1'b1, "R9 cross");
        l_sel_n = 1'b0; l_we = 1'b0; l_idx = 3'd0;
        #2;
        check("R10 index 0", l_dout, 1'b1);
        l_idx = 3'd6;
        #2;
        check("R10 index 6 no wait", l_dout, 1'b0);
        l_sel_n = 1'b1;
        wr(1, 3'd6, 1, 1, 3'd7, 1);
        peek(3'd6, 3'd7, 1'b1, 1'b1, "R9 released");
    endtask

    initial begin
        #1;
        peek(3'd0, 3'd0, 1'b1, 1'b1, "R1 in reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grant_block_handoff();
        t_tie();
        t_cancel();
        t_deselect();
        t_indep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule